// File: doc/BRIEF.md
# Spare-Repairable Systolic Multiply-Accumulate Grid

This block is a 4x4 output-stationary grid of multiply-accumulate elements that forms the product of two square matrices. Left-hand operands enter one per row at the west edge, right-hand operands enter one per logical column at the north edge, and each element passes them on to its east and south neighbours through one register each. Every element adds the product of the two operands it sees into its own accumulator. After the streams have drained, the sixteen sums are presented in logical row-major order.

Each physical row holds one element more than the logical row needs. A per-row repair entry, a valid flag and the index of a defective column, shifts the row's logical columns past the defective position onto the spare. The west-to-east path jumps over the defective element with no register added. Each element's north input comes from the element in the row above that holds the same logical column, so it may come from the upper-left, upper or upper-right element. The repair entries are loaded from fuse inputs once reset is over. A run-time request can claim a row's spare as long as that spare is still free. A request for a row whose spare is already in use is refused and reported.

A fault-emulation input forces chosen physical elements to read and forward zero. It lets a test show that the bypass routing really keeps a defective element out of the result.

Top module: `sa_repair_array`

## Requirements
- R1: `cfg_ready` and `spare_used` are low while `rst_n` is low. At the third rising edge after `rst_n` goes high, the repair entries take `fuse_valid` and `fuse_col` (row r's index in bits [2r+1:2r]), `cfg_ready` rises, and `spare_used` equals `fuse_valid`. After that, fuse inputs are ignored.
- R2: The inputs are streamed with skew: row r's A[r][k] is on `a_in[8r+7:8r]` in cycle t0+k+r, and column j's B[k][j] is on `b_in[8j+7:8j]` in cycle t0+k+j, with zero in every other cycle. Once the streams have drained, `res[24(4r+j)+23:24(4r+j)]` equals the sum over k of A[r][k]*B[k][j], as unsigned numbers.
- R3: A high `acc_clr` at a rising edge zeroes every accumulator, so after that edge all sixteen results read zero.
- R4: If row r's repair entry is valid with index f, then a stuck element at physical (r,f) has no effect on any result. This holds for any mix of repaired and unrepaired rows.
- R5: When a row has no valid repair, its spare (physical column 4) stays idle at zero. A stuck spare in such a row changes no result.
- R6: Bit 5r+p of `flt_inject` makes physical element (r,p) read zero and forward zeros. On an unrepaired row, logical (r,j) is physical (r,j).
- R7: A `rep_req` on a row whose spare is free is taken at the rising edge. From that edge, `spare_used` for the row is set, the row's accumulators are zero, and the other rows' results are unchanged. Later products are correct with the named element stuck.
- R8: A `rep_req` on a row whose spare is already used raises `rep_fail` for exactly one cycle. It leaves `spare_used` and every result unchanged.
- R9: Vertical routing follows logical columns across rows repaired at different columns. This includes a repaired row below a row repaired further left and a row repaired further right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fuse_valid | input | 4 | Per-row fuse repair flag |
| fuse_col | input | 8 | Per-row fuse defective column, 2 bits per row |
| a_in | input | 32 | West-edge operands, 8 bits per row |
| b_in | input | 32 | North-edge operands, 8 bits per logical column |
| acc_clr | input | 1 | Zero all accumulators |
| flt_inject | input | 20 | Stuck-at-zero emulation, bit 5r+p for physical element (r,p) |
| rep_req | input | 1 | Run-time repair request, issued only while streams are idle |
| rep_row | input | 2 | Row of the run-time request |
| rep_col | input | 2 | Defective column of the run-time request |
| rep_fail | output | 1 | One-cycle pulse for a refused request |
| spare_used | output | 4 | Per-row spare-in-use flags |
| cfg_ready | output | 1 | Repair entries loaded |
| res | output | 384 | Sixteen 24-bit sums in logical row-major order |

## Verification
The product is tried with a dense matrix pair and a second pair of different values. It is run with no repairs, with fuse repairs in three rows at columns 1, 3 and 0, and after a run-time repair of the fourth row. The dense pair with no repair shows that the skewed timing is right. The fuse case makes the north operand of a shifted row come from both the upper-left and the upper-right element, so a wrong vertical choice cannot hide. Emulated stuck elements are placed on repaired positions, where they must have no effect, on idle spares, where they must also have no effect, and on one unrepaired element, whose result must go to zero. Together these tell correct bypassing apart from logic that merely ignores the fault input.

// File: rtl/sa_pkg.sv
package sa_pkg;

  // physical column that carries logical column j in a row
  function automatic int phys_of(int j, logic v, int f);
    return (v && j >= f) ? j + 1 : j;
  endfunction

  // logical column carried by physical column p in a row
  function automatic int log_of(int p, logic v, int f);
    return (v && p > f) ? p - 1 : p;
  endfunction

  // physical column p takes part in the computation
  function automatic logic in_use(int p, logic v, int f, int ncols);
    return v ? (p != f) : (p < ncols);
  endfunction

endpackage

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int DW = 8,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          stuck,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [AW-1:0] acc_o
);

  localparam int PW = 2 * DW;

  logic [DW-1:0] a_q, a_d, b_q, b_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [PW-1:0] prod;

  assign prod = a_i * b_i;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    acc_d = acc_q;
    if (clr) begin
      a_d   = '0;
      b_d   = '0;
      acc_d = '0;
    end else if (en) begin
      a_d   = a_i;
      b_d   = b_i;
      acc_d = acc_q + AW'(prod);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      acc_q <= acc_d;
    end
  end

  assign a_o   = stuck ? '0 : a_q;
  assign b_o   = stuck ? '0 : b_q;
  assign acc_o = stuck ? '0 : acc_q;

  // R3: a clear leaves the accumulator at zero
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  // R5: an element that is switched off keeps its state
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_q));

endmodule

// File: rtl/sa_repair_ctrl.sv
module sa_repair_ctrl #(
  parameter int ROWS = 4,
  parameter int FW   = 2,
  parameter int RW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROWS-1:0]    fuse_valid,
  input  logic [ROWS*FW-1:0] fuse_col,
  input  logic               req,
  input  logic [RW-1:0]      req_row,
  input  logic [FW-1:0]      req_col,
  output logic [ROWS-1:0]    rep_v,
  output logic [ROWS*FW-1:0] rep_f,
  output logic               ready,
  output logic               fail,
  output logic [ROWS-1:0]    clr_row
);

  logic [ROWS-1:0]    v_q, v_d;
  logic [ROWS*FW-1:0] f_q, f_d;
  logic               ld_q, ld_d;
  logic               fail_q, fail_d;

  always_comb begin
    v_d     = v_q;
    f_d     = f_q;
    ld_d    = ld_q;
    fail_d  = 1'b0;
    clr_row = '0;
    if (!ld_q) begin
      v_d  = fuse_valid;
      f_d  = fuse_col;
      ld_d = 1'b1;
    end else if (req) begin
      if (v_q[req_row]) begin
        fail_d = 1'b1;
      end else begin
        v_d[req_row]            = 1'b1;
        f_d[req_row*FW +: FW]   = req_col;
        clr_row[req_row]        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      f_q    <= '0;
      ld_q   <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      v_q    <= v_d;
      f_q    <= f_d;
      ld_q   <= ld_d;
      fail_q <= fail_d;
    end
  end

  assign rep_v = v_q;
  assign rep_f = f_q;
  assign ready = ld_q;
  assign fail  = fail_q;

  // R1: the load takes the fuse flags
  assert_fuse_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (rep_v == $past(fuse_valid)));

  // R7: an accepted request claims the spare
  assert_online_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && !rep_v[req_row]) |=> (rep_v[$past(req_row)] && !fail));

  // R8: a refused request pulses fail and changes nothing
  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && rep_v[req_row]) |=> (fail && $stable(rep_v) && $stable(rep_f)));

  // R8: spares once taken are never released
  assert_spare_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rep_v) & ~rep_v) == '0));

endmodule

// File: rtl/sa_repair_array.sv
module sa_repair_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROWS-1:0]          fuse_valid,
  input  logic [ROWS*$clog2(COLS)-1:0] fuse_col,
  input  logic [ROWS*DW-1:0]       a_in,
  input  logic [COLS*DW-1:0]       b_in,
  input  logic                     acc_clr,
  input  logic [ROWS*(COLS+1)-1:0] flt_inject,
  input  logic                     rep_req,
  input  logic [$clog2(ROWS)-1:0]  rep_row,
  input  logic [$clog2(COLS)-1:0]  rep_col,
  output logic                     rep_fail,
  output logic [ROWS-1:0]          spare_used,
  output logic                     cfg_ready,
  output logic [ROWS*COLS*AW-1:0]  res
);
  import sa_pkg::*;

  localparam int PC = COLS + 1;
  localparam int FW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic rs1_q, rs2_q, rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  logic [ROWS-1:0]    rep_v;
  logic [ROWS*FW-1:0] rep_f;
  logic [ROWS-1:0]    clr_row;
  logic               ready;

  sa_repair_ctrl #(.ROWS(ROWS), .FW(FW), .RW(RW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i),
    .fuse_valid (fuse_valid),
    .fuse_col   (fuse_col),
    .req        (rep_req),
    .req_row    (rep_row),
    .req_col    (rep_col),
    .rep_v      (rep_v),
    .rep_f      (rep_f),
    .ready      (ready),
    .fail       (rep_fail),
    .clr_row    (clr_row)
  );

  assign spare_used = rep_v;
  assign cfg_ready  = ready;

  logic [DW-1:0] a_o   [ROWS][PC];
  logic [DW-1:0] b_o   [ROWS][PC];
  logic [AW-1:0] acc_o [ROWS][PC];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar p = 0; p < PC; p++) begin : g_col
      logic [DW-1:0] a_s, b_s;
      logic          en_s;

      // west operand: skip over the defective position without a register
      always_comb begin
        int src;
        src = p - 1;
        if (rep_v[r] && int'(rep_f[r*FW +: FW]) == src) src = src - 1;
        if (src < 0) a_s = a_in[r*DW +: DW];
        else         a_s = a_o[r][src];
      end

      // north operand: element above holding the same logical column
      always_comb begin
        int j;
        j = log_of(p, rep_v[r], int'(rep_f[r*FW +: FW]));
        if (j > COLS - 1) j = COLS - 1;
        if (r == 0) begin
          b_s = b_in[j*DW +: DW];
        end else begin
          b_s = b_o[(r == 0) ? 0 : r-1]
                   [phys_of(j, rep_v[(r == 0) ? 0 : r-1],
                            int'(rep_f[((r == 0) ? 0 : r-1)*FW +: FW]))];
        end
      end

      assign en_s = ready && in_use(p, rep_v[r], int'(rep_f[r*FW +: FW]), COLS);

      sa_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk   (clk),
        .rst_n (rst_i),
        .en    (en_s),
        .clr   (acc_clr || clr_row[r]),
        .stuck (flt_inject[r*PC+p]),
        .a_i   (a_s),
        .b_i   (b_s),
        .a_o   (a_o[r][p]),
        .b_o   (b_o[r][p]),
        .acc_o (acc_o[r][p])
      );
    end

    for (genvar j = 0; j < COLS; j++) begin : g_out
      assign res[(r*COLS+j)*AW +: AW] =
        acc_o[r][phys_of(j, rep_v[r], int'(rep_f[r*FW +: FW]))];
    end

    // R5: a row without repair keeps its spare at zero
    assert_spare_idle_R5: assert property (@(posedge clk) disable iff (!rst_i)
      !rep_v[r] |-> (acc_o[r][COLS] == '0));

    // R7: an accepted repair empties the whole logical row
    assert_row_cleared_R7: assert property (@(posedge clk) disable iff (!rst_i)
      clr_row[r] |=> (res[r*COLS*AW +: COLS*AW] == '0));
  end

endmodule

// File: tb/sa_repair_array_bench.sv
module sa_repair_array_bench;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 24;
  localparam int PC = N + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N-1:0]      fuse_valid;
  logic [2*N-1:0]    fuse_col;
  logic [N*DW-1:0]   a_in, b_in;
  logic              acc_clr;
  logic [N*PC-1:0]   flt_inject;
  logic              rep_req;
  logic [1:0]        rep_row, rep_col;
  logic              rep_fail;
  logic [N-1:0]      spare_used;
  logic              cfg_ready;
  logic [N*N*AW-1:0] res;

  sa_repair_array u_sa_repair_array (
    .clk(clk), .rst_n(rst_n), .fuse_valid(fuse_valid), .fuse_col(fuse_col),
    .a_in(a_in), .b_in(b_in), .acc_clr(acc_clr), .flt_inject(flt_inject),
    .rep_req(rep_req), .rep_row(rep_row), .rep_col(rep_col),
    .rep_fail(rep_fail), .spare_used(spare_used), .cfg_ready(cfg_ready), .res(res)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ma [N][N];
  int mb [N][N];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint get(int r, int j);
    return longint'(res[(r*N+j)*AW +: AW]);
  endfunction

  function automatic longint ref_of(int r, int j);
    longint s = 0;
    for (int k = 0; k < N; k++) s += ma[r][k] * mb[k][j];
    return s;
  endfunction

  task automatic set_mats(int seed);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = (r * 7 + c * 3 + seed) % 251 + 1;
        mb[r][c] = (r * 5 + c * 11 + seed * 3) % 241 + 2;
      end
  endtask

  task automatic do_reset(logic [N-1:0] fv, logic [2*N-1:0] fc);
    rst_n = 1'b0; fuse_valid = fv; fuse_col = fc;
    a_in = '0; b_in = '0; acc_clr = 1'b0; flt_inject = '0;
    rep_req = 1'b0; rep_row = '0; rep_col = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", cfg_ready, 0);
    chk("R1 spares in reset", spare_used, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready before load", cfg_ready, 0);
    @(negedge clk);
    chk("R1 ready after load", cfg_ready, 1);
    chk("R1 spares after load", spare_used, fv);
    fuse_valid = ~fv;
  endtask

  task automatic run_mm();
    acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    for (int t = 0; t < 3 * N; t++) begin
      for (int r = 0; r < N; r++)
        a_in[r*DW +: DW] = (t - r >= 0 && t - r < N) ? DW'(ma[r][t-r]) : '0;
      for (int j = 0; j < N; j++)
        b_in[j*DW +: DW] = (t - j >= 0 && t - j < N) ? DW'(mb[t-j][j]) : '0;
      @(negedge clk);
    end
    a_in = '0; b_in = '0;
    repeat (2 * N) @(negedge clk);
  endtask

  task automatic check_prod(string req);
    for (int r = 0; r < N; r++)
      for (int j = 0; j < N; j++) chk(req, get(r, j), ref_of(r, j));
  endtask

  // R1, R2, R3, R5, R6 on an array without repair
  task automatic t_plain();
    do_reset('0, '0);
    for (int r = 0; r < N; r++)
      for (int j = 0; j < N; j++) chk("R1 result zero after reset", get(r, j), 0);
    set_mats(0);
    run_mm();
    check_prod("R2 plain product");
    acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    for (int r = 0; r < N; r++)
      for (int j = 0; j < N; j++) chk("R3 cleared", get(r, j), 0);
    for (int r = 0; r < N; r++) flt_inject[r*PC + N] = 1'b1;
    set_mats(17);
    run_mm();
    check_prod("R5 stuck idle spares");
    flt_inject = '0;
    flt_inject[1*PC + 2] = 1'b1;
    run_mm();
    chk("R6 unrepaired stuck reads zero", get(1, 2), 0);
    chk("R6 rows above untouched", get(0, 2), ref_of(0, 2));
    flt_inject = '0;
  endtask

  // R4, R9 fuse repair (row0 col1, row1 col3, row2 col0), then R7 and R8
  task automatic t_repair();
    logic [N*N*AW-1:0] snap;
    do_reset(4'b0111, 8'b00_00_11_01);
    flt_inject = '0;
    flt_inject[0*PC + 1] = 1'b1;
    flt_inject[1*PC + 3] = 1'b1;
    flt_inject[2*PC + 0] = 1'b1;
    set_mats(5);
    run_mm();
    check_prod("R4 R9 fuse repaired product");
    snap = res;
    rep_row = 2'd3; rep_col = 2'd2; rep_req = 1'b1;
    @(negedge clk);
    rep_req = 1'b0;
    chk("R7 spare claimed", spare_used, 4'b1111);
    chk("R7 no fail", rep_fail, 0);
    for (int j = 0; j < N; j++) chk("R7 row cleared", get(3, j), 0);
    for (int r = 0; r < N - 1; r++)
      for (int j = 0; j < N; j++)
        chk("R7 other rows kept", get(r, j), longint'(snap[(r*N+j)*AW +: AW]));
    flt_inject[3*PC + 2] = 1'b1;
    set_mats(29);
    run_mm();
    check_prod("R7 product after online repair");
    snap = res;
    rep_row = 2'd0; rep_col = 2'd0; rep_req = 1'b1;
    @(negedge clk);
    rep_req = 1'b0;
    chk("R8 fail pulse", rep_fail, 1);
    chk("R8 spares kept", spare_used, 4'b1111);
    @(negedge clk);
    chk("R8 fail one cycle", rep_fail, 0);
    chk("R8 results kept", (res == snap) ? 1 : 0, 1);
    run_mm();
    check_prod("R8 mapping kept after refusal");
  endtask

  initial begin
    t_plain();
    t_repair();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule